// File: doc/BRIEF.md
# Exception Base Register with Write Gate

This block holds the 32-bit exception base address that a processor core builds its exception vectors from. It keeps one copy of the register for each hardware thread context. Software can load the copy of the context it runs on through a local write port. It can also load another context's copy through a remote write port that names the target context with an 8-bit index. A single read port returns the copy of the current context.

The middle address field, bits 29:12, can always be written. Bits 31:30 are protected by a gate bit at position 11. They change only in a write whose data has bit 11 set, and only when the gate is built in. A build-time parameter decides whether the gate exists. Without it, bit 11 reads as zero and bits 31:30 keep their reset value, so software that probes for the gate finds it absent. Bits 9:0 return a CPU number taken from an input pin, and bit 10 reads as zero. A second parameter picks the reset base for a virtualisation-host configuration.

Top module: `ebase_reg`

## Requirements
- R1: After reset every copy reads base 0x80000000, or 0x40000000 when HOST_RESET is 1. Bits 29:12 and the gate bit (bit 11) are zero.
- R2: A local write loads data bits 29:12 into the current context's copy on the clock edge where wr_en is high, and the read port shows the new value in the next cycle.
- R3: With WG_PRESENT=1, bit 11 stores the written bit 11. When data bit 11 is 1, bits 31:30 take data bits 31:30 in that same write.
- R4: A write whose data bit 11 is 0 clears the stored gate bit and leaves bits 31:30 unchanged.
- R5: With WG_PRESENT=0, bit 11 always reads 0 and bits 31:30 never change after reset, whatever is written.
- R6: Read bits 9:0 follow the cpu_num input combinationally and bit 10 reads 0. Written data bits 10:0 have no effect.
- R7: A remote write applies the same masking to the copy selected by rmt_ctx, and leaves every other copy unchanged.
- R8: A remote write whose rmt_ctx is NUM_CTX or larger changes no copy.
- R9: When a local write and a remote write hit the same context in the same cycle, the local data wins. When they hit different contexts, both take effect.
- R10: A copy holds its value in every cycle in which no write is aimed at it.
- R11: rd_data shows the copy selected by cur_ctx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cpu_num | input | 10 | CPU number returned in read bits 9:0 |
| cur_ctx | input | CTX_W | Context the local port and the read port act on |
| wr_en | input | 1 | Local write enable |
| wr_data | input | 32 | Local write data |
| rmt_en | input | 1 | Remote write enable |
| rmt_ctx | input | 8 | Target context of the remote write |
| rmt_data | input | 32 | Remote write data |
| rd_data | output | 32 | Current context's register value |

## Verification
The hardest situations to reach are the collisions: a local and a remote write landing on the same copy in one cycle, and a remote write whose index wraps onto a real context once it is truncated. The bench drives both write ports in the same cycle, first to one context and then to two different ones. It also sends a remote write to index 5 and then reads context 1, which an index truncated to two bits would hit. Two instances run on the same stimulus, one with the gate and one without. This shows that the same writes move bits 31:30 in the first instance and never in the second.

// File: rtl/ebase_pkg.sv
package ebase_pkg;
  localparam int GATE_POS = 11;
  localparam int MID_LO   = 12;
  localparam int MID_HI   = 29;
  localparam int MID_W    = MID_HI - MID_LO + 1;
  localparam int TOP_LO   = 30;

  typedef struct packed {
    logic [1:0]       top;
    logic [MID_W-1:0] mid;
    logic             gate;
  } ebase_state_t;
endpackage

// File: rtl/ebase_rst_sync.sv
module ebase_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) stage_q <= 2'b00;
    else           stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_out = stage_q[1];
endmodule

// File: rtl/ebase_merge.sv
module ebase_merge
  import ebase_pkg::*;
#(
  parameter bit WG_PRESENT = 1'b1
) (
  input  ebase_state_t cur,
  input  logic [31:GATE_POS] data,
  output ebase_state_t nxt
);
  generate
    if (WG_PRESENT) begin : g_gate
      always_comb begin
        nxt.mid  = data[MID_HI:MID_LO];
        nxt.gate = data[GATE_POS];
        nxt.top  = data[GATE_POS] ? data[31:TOP_LO] : cur.top;
      end
    end else begin : g_nogate
      logic unused_hi;
      assign unused_hi = ^{data[31:TOP_LO], data[GATE_POS], cur.gate};
      always_comb begin
        nxt.mid  = data[MID_HI:MID_LO];
        nxt.gate = 1'b0;
        nxt.top  = cur.top;
      end
    end
  endgenerate
endmodule

// File: rtl/ebase_slot.sv
module ebase_slot
  import ebase_pkg::*;
#(
  parameter bit WG_PRESENT = 1'b1,
  parameter bit HOST_RESET = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [31:GATE_POS] wdata,
  output ebase_state_t       q
);
  localparam logic [1:0] RST_TOP = HOST_RESET ? 2'b01 : 2'b10;

  ebase_state_t merged;
  ebase_state_t q_next;

  ebase_merge #(.WG_PRESENT(WG_PRESENT)) u_merge (
    .cur  (q),
    .data (wdata),
    .nxt  (merged)
  );

  always_comb begin
    q_next = q;
    if (we) q_next = merged;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.top  <= RST_TOP;
      q.mid  <= '0;
      q.gate <= 1'b0;
    end else begin
      q <= q_next;
    end
  end

  // R2: middle field loaded from the write data
  assert_mid_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> q.mid == $past(wdata[MID_HI:MID_LO]));

  // R3 and R5: the top bits move only in a gated write
  assert_top_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(q.top) |-> $past(we && wdata[GATE_POS] && WG_PRESENT));

  // R4: a write without the gate bit keeps the top and clears the gate
  assert_ungated_keeps_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !wdata[GATE_POS]) |=> (q.top == $past(q.top)) && !q.gate);

  // R10: no write, no change
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));
endmodule

// File: rtl/ebase_reg.sv
module ebase_reg
  import ebase_pkg::*;
#(
  parameter int NUM_CTX    = 4,
  parameter bit WG_PRESENT = 1'b1,
  parameter bit HOST_RESET = 1'b0,
  localparam int CTX_W     = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [9:0]       cpu_num,
  input  logic [CTX_W-1:0] cur_ctx,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  input  logic             rmt_en,
  input  logic [7:0]       rmt_ctx,
  input  logic [31:0]      rmt_data,
  output logic [31:0]      rd_data
);
  logic rst_sync_n;
  logic unused_low;
  ebase_state_t slot_q [NUM_CTX];
  ebase_state_t rd_state;

  assign unused_low = ^{wr_data[GATE_POS-1:0], rmt_data[GATE_POS-1:0]};

  ebase_rst_sync u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  generate
    for (genvar i = 0; i < NUM_CTX; i++) begin : g_ctx
      logic loc_hit;
      logic rmt_hit;
      logic slot_we;
      logic [31:GATE_POS] slot_wdata;

      always_comb begin
        loc_hit    = wr_en && (int'(cur_ctx) == i);
        rmt_hit    = rmt_en && (int'(rmt_ctx) == i);
        slot_we    = loc_hit || rmt_hit;
        slot_wdata = loc_hit ? wr_data[31:GATE_POS] : rmt_data[31:GATE_POS];
      end

      ebase_slot #(
        .WG_PRESENT (WG_PRESENT),
        .HOST_RESET (HOST_RESET)
      ) u_slot (
        .clk   (clk),
        .rst_n (rst_sync_n),
        .we    (slot_we),
        .wdata (slot_wdata),
        .q     (slot_q[i])
      );
    end
  endgenerate

  always_comb begin
    rd_state = '0;
    for (int i = 0; i < NUM_CTX; i++) begin
      if (int'(cur_ctx) == i) rd_state = slot_q[i];
    end
  end

  assign rd_data = {rd_state.top, rd_state.mid, rd_state.gate, 1'b0, cpu_num};

  // R8: a remote write to a missing context leaves the visible value alone
  assert_bad_ctx_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rmt_en && !wr_en && int'(rmt_ctx) >= NUM_CTX) |=>
      (!$stable(cur_ctx) || !$stable(cpu_num) || $stable(rd_data)));
endmodule

// File: tb/ebase_reg_bench.sv
module ebase_reg_bench;
  logic        clk;
  logic        rst_n;
  logic [9:0]  cpu_num;
  logic [1:0]  cur_ctx;
  logic        wr_en;
  logic [31:0] wr_data;
  logic        rmt_en;
  logic [7:0]  rmt_ctx;
  logic [31:0] rmt_data;
  logic [31:0] rd_a;
  logic [31:0] rd_b;
  int          n_checks = 0;
  int          n_fails  = 0;

  // {write data, expected with gate, expected without gate}; cpu_num = 0x155
  localparam logic [95:0] VEC [6] = '{
    {32'h1234_5FFF, 32'h1234_5955, 32'h5234_5155},
    {32'hC000_1000, 32'h0000_1155, 32'h4000_1155},
    {32'hC000_0800, 32'hC000_0955, 32'h4000_0155},
    {32'h3FFF_F7FF, 32'hFFFF_F155, 32'h7FFF_F155},
    {32'h40AB_C800, 32'h40AB_C955, 32'h40AB_C155},
    {32'h0000_0000, 32'h4000_0155, 32'h4000_0155}
  };

  ebase_reg #(.NUM_CTX(4), .WG_PRESENT(1'b1), .HOST_RESET(1'b0)) u_ebase_reg (
    .clk(clk), .rst_n(rst_n), .cpu_num(cpu_num), .cur_ctx(cur_ctx),
    .wr_en(wr_en), .wr_data(wr_data), .rmt_en(rmt_en), .rmt_ctx(rmt_ctx),
    .rmt_data(rmt_data), .rd_data(rd_a)
  );

  ebase_reg #(.NUM_CTX(4), .WG_PRESENT(1'b0), .HOST_RESET(1'b1)) u_ebase_reg_nowg (
    .clk(clk), .rst_n(rst_n), .cpu_num(cpu_num), .cur_ctx(cur_ctx),
    .wr_en(wr_en), .wr_data(wr_data), .rmt_en(rmt_en), .rmt_ctx(rmt_ctx),
    .rmt_data(rmt_data), .rd_data(rd_b)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic drive(input bit le, input logic [1:0] cc, input logic [31:0] wd,
                       input bit re, input logic [7:0] rc, input logic [31:0] rd);
    @(negedge clk);
    cur_ctx  = cc;
    wr_en    = le;
    wr_data  = wd;
    rmt_en   = re;
    rmt_ctx  = rc;
    rmt_data = rd;
    @(negedge clk);
    wr_en  = 1'b0;
    rmt_en = 1'b0;
  endtask

  task automatic look(input logic [1:0] cc, input string req,
                      input logic [31:0] exp_a, input logic [31:0] exp_b);
    cur_ctx = cc;
    #1;
    check({req, " gated"}, rd_a, exp_a);
    check({req, " ungated"}, rd_b, exp_b);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cpu_num = 10'h155; cur_ctx = 2'd0;
    wr_en = 1'b0; wr_data = '0; rmt_en = 1'b0; rmt_ctx = '0; rmt_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    look(2'd0, "R1 reset ctx0", 32'h8000_0155, 32'h4000_0155);
    look(2'd3, "R1 reset ctx3", 32'h8000_0155, 32'h4000_0155);

    // R6: low bits follow cpu_num, bit 10 reads zero
    cur_ctx = 2'd0;
    cpu_num = 10'h2AA;
    #1;
    check("R6 cpu_num", rd_a, 32'h8000_02AA);
    cpu_num = 10'h155;
    #1;

    // R2 R3 R4 R5 R6: vector walk on context 0 through the local port
    foreach (VEC[k]) begin
      drive(1'b1, 2'd0, VEC[k][95:64], 1'b0, 8'd0, 32'd0);
      look(2'd0, $sformatf("R2/R3/R4/R5/R6 vec%0d", k), VEC[k][63:32], VEC[k][31:0]);
    end

    // R7: remote write to context 2 while running on context 0
    drive(1'b0, 2'd0, 32'd0, 1'b1, 8'd2, 32'hC005_5800);
    look(2'd2, "R7 target", 32'hC005_5955, 32'h4005_5155);
    look(2'd0, "R7 others", 32'h4000_0155, 32'h4000_0155);

    // R8: index 5 is beyond the last context and must not alias onto context 1
    drive(1'b0, 2'd0, 32'd0, 1'b1, 8'd5, 32'hC0FF_F800);
    look(2'd1, "R8 ctx1", 32'h8000_0155, 32'h4000_0155);
    look(2'd0, "R8 ctx0", 32'h4000_0155, 32'h4000_0155);

    // R9: same-context collision, local data wins
    drive(1'b1, 2'd1, 32'h0011_1000, 1'b1, 8'd1, 32'h0022_2000);
    look(2'd1, "R9 same", 32'h8011_1155, 32'h4011_1155);

    // R9: different contexts, both writes land
    drive(1'b1, 2'd3, 32'h0033_3000, 1'b1, 8'd0, 32'h0044_4000);
    look(2'd3, "R9 local", 32'h8033_3155, 32'h4033_3155);
    look(2'd0, "R9 remote", 32'h4044_4155, 32'h4044_4155);

    // R10 R11: idle cycles hold, read follows cur_ctx
    repeat (5) @(negedge clk);
    look(2'd2, "R10/R11 ctx2", 32'hC005_5955, 32'h4005_5155);
    look(2'd1, "R10/R11 ctx1", 32'h8011_1155, 32'h4011_1155);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule